// File: doc/BRIEF.md
# Three-Stage Branching Program Sequencer

This block runs a small instruction stream through a three-stage pipeline: fetch, decode, and a merged execute/writeback stage. It drives a fetch address, takes back the instruction word stored at that address in the same cycle, and executes a compact instruction set. The set covers compare, register-to-register compute, immediate load, jump, call and return. Every branch resolves in the last stage, so two younger instructions are already in flight when a branch is taken.

A taken branch can either discard those two instructions or, when marked delayed, let them complete before the target runs. A condition field qualifies the whole instruction against the zero and negative flags. This means a compute can be made conditional in place of a short branch around it. Return addresses go on a small on-chip stack, and misuse of that stack raises a sticky error.

Execute-stage activity is visible at the ports for observation: the executing address, the register write and the illegal-instruction strobe.

Top module: `branch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. The fetch address goes to 0, the decode and execute stages become empty (`exec_valid` low), both flags clear, the return stack empties and `stack_err` clears.
- R2: Without a taken branch, the fetch address advances by one each cycle. An instruction fetched at address A is in the execute stage two cycles after it is fetched, and `exec_pc` shows A.
- R3: Instruction fields are placed as follows. The opcode is in [47:44], with 0 nop, 1 compare, 2 compute, 3 immediate load, 4 jump, 5 call and 6 return. The condition is in [43:40] and the delayed flag in [39]. The compute function is in [38:37]. Bit [36] is reserved. The destination register is in [35:32], the first source in [31:28] and the second source in [27:24]. The immediate is in [31:0] and the branch target in [23:0].
- R4: Compute writes its result to the destination register, shown on `wr_en`/`wr_idx`/`wr_data` while the instruction is in execute. The functions are 0 add, 1 subtract (first minus second), 2 pass first source, and 3 signed minimum. Compute also sets the zero flag (result is 0) and the negative flag (result bit 31).
- R5: Compare sets the zero and negative flags from the first source minus the second and writes no register. The very next instruction is evaluated against the updated flags.
- R6: The condition codes are 0 always, 1 zero, 2 not zero, 3 negative, 4 not negative, 5 zero or negative, and 6 neither. A compute whose condition is false writes nothing and leaves the flags unchanged. An immediate load does not touch the flags.
- R7: A jump, call or return whose condition is false acts as a nop. The next sequential instruction executes in the following cycle.
- R8: A taken branch without the delayed flag discards the two instructions behind it. They write no register, flag or stack entry. The target executes three cycles after the branch.
- R9: A taken branch with the delayed flag lets the two following instructions execute normally. The target executes in the cycle right after them, three cycles after the branch.
- R10: A taken call pushes its own address plus 1 (normal) or plus 3 (delayed). A taken return pops that address and branches to it under the same normal/delayed rules as a jump.
- R11: An instruction is illegal if its opcode is 7 to 15, its condition is 7 to 15, its bit [36] is set, or it is an immediate load with a nonzero condition. An illegal instruction raises `exec_illegal` for its execute cycle and has no other effect.
- R12: The return stack holds 4 entries. A call made with the stack full is still taken, but it pushes nothing and sets `stack_err`. A return made with the stack empty does not branch and sets `stack_err`. Only reset clears `stack_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | output | 24 | Address of the instruction being fetched |
| instr_word | input | 48 | Instruction stored at `fetch_addr`, valid in the same cycle |
| exec_valid | output | 1 | Execute stage holds a live instruction |
| exec_pc | output | 24 | Address of the instruction in execute |
| exec_illegal | output | 1 | Instruction in execute is an illegal encoding |
| wr_en | output | 1 | Register write from execute this cycle |
| wr_idx | output | 4 | Destination register of the write |
| wr_data | output | 32 | Data written |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| stack_err | output | 1 | Sticky return-stack overflow/underflow |

## Verification
The bench targets the edges of branch handling: the two slots behind a normal branch, the delay slots of delayed jumps and returns, and the return address a delayed call saves. A design that lets a flushed slot write shows an extra register write. A wrong saved address makes the return land one or three instructions off. It also checks that a conditional instruction placed straight after a compare sees the new flags; reading stale flags would write when it must not. Stack overflow, stack underflow and each illegal form are driven directly, because a design that treated them loosely would silently redirect or write.

// File: rtl/branch_seq_pkg.sv
// Package: shared encoding constants and the decoded-instruction record.
// Assumes 48-bit instruction words and 24-bit addresses throughout.
package branch_seq_pkg;
    localparam int IW = 48;
    localparam int AW = 24;
    localparam int DW = 32;

    localparam logic [3:0] OP_NOP  = 4'd0;
    localparam logic [3:0] OP_COMP = 4'd1;
    localparam logic [3:0] OP_ALU  = 4'd2;
    localparam logic [3:0] OP_LDI  = 4'd3;
    localparam logic [3:0] OP_JUMP = 4'd4;
    localparam logic [3:0] OP_CALL = 4'd5;
    localparam logic [3:0] OP_RET  = 4'd6;

    localparam logic [3:0] CC_ALWAYS = 4'd0;
    localparam logic [3:0] CC_EQ     = 4'd1;
    localparam logic [3:0] CC_NE     = 4'd2;
    localparam logic [3:0] CC_LT     = 4'd3;
    localparam logic [3:0] CC_GE     = 4'd4;
    localparam logic [3:0] CC_LE     = 4'd5;
    localparam logic [3:0] CC_GT     = 4'd6;

    localparam logic [1:0] FN_ADD  = 2'd0;
    localparam logic [1:0] FN_SUB  = 2'd1;
    localparam logic [1:0] FN_PASS = 2'd2;
    localparam logic [1:0] FN_MIN  = 2'd3;

    typedef struct packed {
        logic          is_comp;
        logic          is_alu;
        logic          is_ldi;
        logic          is_jump;
        logic          is_call;
        logic          is_ret;
        logic          bad;
        logic [3:0]    cond;
        logic          delayed;
        logic [1:0]    func;
        logic [3:0]    rd;
        logic [3:0]    rx;
        logic [3:0]    ry;
        logic [DW-1:0] imm;
        logic [AW-1:0] target;
    } dec_t;
endpackage

// File: rtl/bs_decode.sv
// Module: bs_decode
// Splits an instruction word into fields and opcode strobes, and flags
// illegal encodings. Purely combinational; assumes the field layout of
// branch_seq_pkg.
module bs_decode
    import branch_seq_pkg::*;
(
    input  logic [IW-1:0] iw,
    output dec_t          dec
);
    logic [3:0] op;
    assign op = iw[47:44];

    // Field extraction, opcode strobes and legality check.
    always_comb begin
        dec         = '0;
        dec.cond    = iw[43:40];
        dec.delayed = iw[39];
        dec.func    = iw[38:37];
        dec.rd      = iw[35:32];
        dec.rx      = iw[31:28];
        dec.ry      = iw[27:24];
        dec.imm     = iw[31:0];
        dec.target  = iw[23:0];
        case (op)
            OP_NOP:  ;
            OP_COMP: dec.is_comp = 1'b1;
            OP_ALU:  dec.is_alu  = 1'b1;
            OP_LDI:  dec.is_ldi  = 1'b1;
            OP_JUMP: dec.is_jump = 1'b1;
            OP_CALL: dec.is_call = 1'b1;
            OP_RET:  dec.is_ret  = 1'b1;
            default: dec.bad     = 1'b1;
        endcase
        if (iw[43:40] > CC_GT) dec.bad = 1'b1;
        if (iw[36]) dec.bad = 1'b1;
        if (op == OP_LDI && iw[43:40] != CC_ALWAYS) dec.bad = 1'b1;
    end
endmodule

// File: rtl/bs_cond_eval.sv
// Module: bs_cond_eval
// Tests a condition code against the zero and negative flags.
// Codes above the last defined one evaluate false (decode marks them illegal).
module bs_cond_eval
    import branch_seq_pkg::*;
(
    input  logic [3:0] cond,
    input  logic       fz,
    input  logic       fn,
    output logic       pass
);
    // Condition truth table.
    always_comb begin
        case (cond)
            CC_ALWAYS: pass = 1'b1;
            CC_EQ:     pass = fz;
            CC_NE:     pass = ~fz;
            CC_LT:     pass = fn;
            CC_GE:     pass = ~fn;
            CC_LE:     pass = fz | fn;
            CC_GT:     pass = ~fz & ~fn;
            default:   pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/bs_ret_stack.sv
// Module: bs_ret_stack
// Return-address stack of DEPTH entries. A push when full and a pop when
// empty leave the contents alone and set a sticky error. Assumes push and
// pop are never requested in the same cycle.
module bs_ret_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          empty,
    output logic          err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] slot [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign top_addr = slot[PW'(cnt - CW'(1))];

    // Occupancy count and sticky misuse flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (push) begin
            if (full) err <= 1'b1;
            else      cnt <= cnt + CW'(1);
        end else if (pop) begin
            if (empty) err <= 1'b1;
            else       cnt <= cnt - CW'(1);
        end
    end

    // Entry storage, written on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !full) slot[PW'(cnt)] <= push_addr;
    end
endmodule

// File: rtl/bs_regfile.sv
// Module: bs_regfile
// Register file with two combinational read ports and one write port.
// All registers clear on reset.
module bs_regfile #(
    parameter int NREGS = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_a,
    output logic [DW-1:0]            rdata_b
);
    logic [DW-1:0] mem [NREGS];

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // Clear on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/branch_seq.sv
// Module: branch_seq (top)
// Three-stage sequencer: fetch (pc register), decode latch and execute.
// Branches, flag updates, register writes and stack operations all take
// effect at the end of the execute cycle. Assumes instr_word returns the
// word at fetch_addr in the same cycle, and that no taken branch is placed
// in the delay slots of a delayed branch.
module branch_seq
    import branch_seq_pkg::*;
#(
    parameter int NREGS    = 16,
    parameter int RS_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [AW-1:0]            fetch_addr,
    input  logic [IW-1:0]            instr_word,
    output logic                     exec_valid,
    output logic [AW-1:0]            exec_pc,
    output logic                     exec_illegal,
    output logic                     wr_en,
    output logic [$clog2(NREGS)-1:0] wr_idx,
    output logic [DW-1:0]            wr_data,
    output logic                     flag_z,
    output logic                     flag_n,
    output logic                     stack_err
);
    localparam int RIW = $clog2(NREGS);

    logic [AW-1:0] pc_q;
    logic          d_valid, e_valid;
    logic [IW-1:0] d_iw, e_iw;
    logic [AW-1:0] d_pc, e_pc;
    logic          fz_q, fn_q;

    dec_t          dec;
    logic          cond_ok, act;
    logic [DW-1:0] ra, rb, diff, alu_res, flag_src;
    logic          flag_we;
    logic          br_take, br_flush;
    logic [AW-1:0] br_tgt, push_addr, rs_top;
    logic          rs_empty, rs_push, rs_pop;

    bs_decode u_dec (.iw(e_iw), .dec(dec));

    bs_cond_eval u_cond (.cond(dec.cond), .fz(fz_q), .fn(fn_q), .pass(cond_ok));

    bs_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
        .raddr_a(dec.rx[RIW-1:0]), .raddr_b(dec.ry[RIW-1:0]),
        .rdata_a(ra), .rdata_b(rb)
    );

    bs_ret_stack #(.DEPTH(RS_DEPTH), .AW(AW)) u_rs (
        .clk(clk), .rst_n(rst_n),
        .push(rs_push), .pop(rs_pop), .push_addr(push_addr),
        .top_addr(rs_top), .empty(rs_empty), .err(stack_err)
    );

    // An instruction acts only if live, legal and its condition holds.
    assign act  = e_valid && !dec.bad && cond_ok;
    assign diff = ra - rb;

    // Compute function select.
    always_comb begin
        case (dec.func)
            FN_ADD:  alu_res = ra + rb;
            FN_SUB:  alu_res = diff;
            FN_PASS: alu_res = ra;
            default: alu_res = ($signed(ra) < $signed(rb)) ? ra : rb;
        endcase
    end

    assign flag_we  = act && (dec.is_comp || dec.is_alu);
    assign flag_src = dec.is_comp ? diff : alu_res;

    assign wr_en   = act && (dec.is_alu || dec.is_ldi);
    assign wr_idx  = dec.rd[RIW-1:0];
    assign wr_data = dec.is_ldi ? dec.imm : alu_res;

    // Branch resolution; a return with an empty stack does not redirect.
    assign rs_push   = act && dec.is_call;
    assign rs_pop    = act && dec.is_ret;
    assign push_addr = e_pc + (dec.delayed ? AW'(3) : AW'(1));
    assign br_take   = act && (dec.is_jump || dec.is_call || (dec.is_ret && !rs_empty));
    assign br_tgt    = dec.is_ret ? rs_top : dec.target;
    assign br_flush  = br_take && !dec.delayed;

    // Fetch address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (br_take) pc_q <= br_tgt;
        else              pc_q <= pc_q + AW'(1);
    end

    // Decode and execute stage registers with flush on a normal branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_valid <= 1'b0;
            e_valid <= 1'b0;
            d_iw    <= '0;
            e_iw    <= '0;
            d_pc    <= '0;
            e_pc    <= '0;
        end else begin
            d_valid <= !br_flush;
            d_iw    <= instr_word;
            d_pc    <= pc_q;
            e_valid <= d_valid && !br_flush;
            e_iw    <= d_iw;
            e_pc    <= d_pc;
        end
    end

    // Status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fz_q <= 1'b0;
            fn_q <= 1'b0;
        end else if (flag_we) begin
            fz_q <= (flag_src == '0);
            fn_q <= flag_src[DW-1];
        end
    end

    assign fetch_addr   = pc_q;
    assign exec_valid   = e_valid;
    assign exec_pc      = e_pc;
    assign exec_illegal = e_valid && dec.bad;
    assign flag_z       = fz_q;
    assign flag_n       = fn_q;
endmodule

// File: rtl/bs_checker.sv
// Module: bs_checker
// Temporal properties of branch_seq, bound to every instance.
// Assumes no taken branch sits in a delay slot.
module bs_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_addr,
    input logic          exec_valid,
    input logic [AW-1:0] exec_pc,
    input logic          exec_illegal,
    input logic          wr_en,
    input logic          stack_err,
    input logic          br_take,
    input logic          br_flush
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0 && !exec_valid));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_illegal |-> !wr_en);

    // R8
    write_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> exec_valid);

    // R8
    flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_flush |=> !exec_valid ##1 !exec_valid
                     ##1 (exec_valid && exec_pc == $past(fetch_addr, 2)));

    // R9
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && !br_flush) |=> exec_valid ##1 exec_valid
                     ##1 (exec_valid && exec_pc == $past(fetch_addr, 2)));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
endmodule

bind branch_seq bs_checker #(.AW(branch_seq_pkg::AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .exec_valid(exec_valid), .exec_pc(exec_pc), .exec_illegal(exec_illegal),
    .wr_en(wr_en), .stack_err(stack_err),
    .br_take(br_take), .br_flush(br_flush)
);

// File: tb/branch_seq_tb_top.sv
module branch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fetch_addr;
    logic [47:0] instr_word;
    logic        exec_valid, exec_illegal, wr_en, flag_z, flag_n, stack_err;
    logic [23:0] exec_pc;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;

    logic [47:0] imem [0:255];
    assign instr_word = imem[fetch_addr[7:0]];

    always #4 clk = ~clk;

    branch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .instr_word(instr_word),
        .exec_valid(exec_valid), .exec_pc(exec_pc), .exec_illegal(exec_illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .flag_z(flag_z), .flag_n(flag_n), .stack_err(stack_err)
    );

    int n_chk = 0, n_fail = 0;
    int nex, nwr, nill;
    int ex_pc [0:63];
    int ex_cyc [0:63];
    logic [3:0]  wr_r [0:63];
    logic [31:0] wr_d [0:63];
    logic        err_at [0:63];
    logic [23:0] rs_fa;
    logic        rs_ev, rs_z, rs_n, rs_err, end_z, end_n, end_err;

    // fn, a, b, result, z, n
    localparam logic [99:0] VEC [0:6] = '{
        {2'd0, 32'd5,         32'd7, 32'd12,        1'b0, 1'b0},
        {2'd1, 32'd3,         32'd3, 32'd0,         1'b1, 1'b0},
        {2'd1, 32'd2,         32'd9, 32'hFFFF_FFF9, 1'b0, 1'b1},
        {2'd0, 32'hFFFF_FFFF, 32'd1, 32'd0,         1'b1, 1'b0},
        {2'd2, 32'h8000_0000, 32'd5, 32'h8000_0000, 1'b0, 1'b1},
        {2'd3, 32'hFFFF_FFFC, 32'd3, 32'hFFFF_FFFC, 1'b0, 1'b1},
        {2'd3, 32'd10,        32'd6, 32'd6,         1'b0, 1'b0}
    };

    function automatic logic [47:0] e_alu(logic [3:0] cc, logic [1:0] fn,
                                          logic [3:0] rd, logic [3:0] rx, logic [3:0] ry);
        return {4'h2, cc, 1'b0, fn, 1'b0, rd, rx, ry, 24'b0};
    endfunction
    function automatic logic [47:0] e_ldi(logic [3:0] cc, logic [3:0] rd, logic [31:0] imm);
        return {4'h3, cc, 1'b0, 2'b0, 1'b0, rd, imm};
    endfunction
    function automatic logic [47:0] e_cmp(logic [3:0] rx, logic [3:0] ry);
        return {4'h1, 4'h0, 8'b0, rx, ry, 24'b0};
    endfunction
    function automatic logic [47:0] e_br(logic [3:0] op, logic [3:0] cc, logic db, logic [23:0] t);
        return {op, cc, db, 15'b0, t};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) imem[i] = 48'h0;
    endtask

    task automatic run(input int ncyc);
        rst_n = 1'b0;
        nex = 0; nwr = 0; nill = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rs_fa = fetch_addr; rs_ev = exec_valid; rs_z = flag_z; rs_n = flag_n; rs_err = stack_err;
        rst_n = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (exec_valid) begin ex_pc[nex] = int'(exec_pc); ex_cyc[nex] = c; nex++; end
            if (wr_en) begin wr_r[nwr] = wr_idx; wr_d[nwr] = wr_data; nwr++; end
            if (exec_illegal) nill++;
            err_at[c] = stack_err;
        end
        end_z = flag_z; end_n = flag_n; end_err = stack_err;
    endtask

    function automatic int when(input int pc);
        for (int i = 0; i < nex; i++) if (ex_pc[i] == pc) return ex_cyc[i];
        return -1;
    endfunction

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Vector table: compute functions and their flags
        for (int v = 0; v < 7; v++) begin
            clear_mem();
            imem[0] = e_ldi(4'h0, 4'd1, VEC[v][97:66]);
            imem[1] = e_ldi(4'h0, 4'd2, VEC[v][65:34]);
            imem[2] = e_alu(4'h0, VEC[v][99:98], 4'd3, 4'd1, 4'd2);
            run(10);
            chk(nwr == 3 && wr_r[2] == 4'd3 && wr_d[2] == VEC[v][33:2], "R4 result",
                wr_d[2], VEC[v][33:2]);
            chk(end_z == VEC[v][1] && end_n == VEC[v][0], "R4 flags",
                {end_z, end_n}, VEC[v][1:0]);
            if (v == 0) begin
                chk(rs_fa == 0 && !rs_ev && !rs_err, "R1 reset state", {rs_fa, rs_ev, rs_err}, 0);
                chk(wr_r[0] == 4'd1 && wr_d[0] == 32'd5, "R3 load field", wr_d[0], 5);
                chk(when(1) == when(0) + 1 && when(2) == when(0) + 2, "R2 sequential",
                    when(2) - when(0), 2);
            end
        end

        // R1: flags cleared by reset after the previous run left them set
        chk(rs_z == 0 && rs_n == 0, "R1 flags reset", {rs_z, rs_n}, 0);

        // Compare then conditional computes
        clear_mem();
        imem[0] = e_ldi(4'h0, 4'd1, 32'd5);
        imem[1] = e_ldi(4'h0, 4'd2, 32'd5);
        imem[2] = e_cmp(4'd1, 4'd2);
        imem[3] = e_alu(4'h2, 2'd0, 4'd4, 4'd1, 4'd2);
        imem[4] = e_alu(4'h1, 2'd0, 4'd3, 4'd1, 4'd2);
        imem[5] = e_ldi(4'h0, 4'd6, 32'd1);
        imem[6] = e_cmp(4'd6, 4'd2);
        imem[7] = e_alu(4'h4, 2'd0, 4'd8, 4'd1, 4'd2);
        imem[8] = e_alu(4'h3, 2'd1, 4'd7, 4'd1, 4'd6);
        run(16);
        chk(nwr == 5, "R6 conditional write count", nwr, 5);
        chk(wr_r[2] == 4'd3 && wr_d[2] == 32'd10, "R5 EQ right after compare", wr_d[2], 10);
        chk(wr_r[4] == 4'd7 && wr_d[4] == 32'd4, "R6 LT after negative compare", wr_d[4], 4);
        chk(end_z == 0 && end_n == 0, "R5 flags", {end_z, end_n}, 0);

        // Conditional jump not taken
        clear_mem();
        imem[0] = e_ldi(4'h0, 4'd1, 32'd1);
        imem[1] = e_ldi(4'h0, 4'd2, 32'd2);
        imem[2] = e_cmp(4'd1, 4'd2);
        imem[3] = e_br(4'h4, 4'h1, 1'b0, 24'd20);
        imem[4] = e_ldi(4'h0, 4'd9, 32'h44);
        run(12);
        chk(when(4) == when(3) + 1 && when(20) == -1, "R7 false jump is nop", when(4) - when(3), 1);
        chk(nwr == 3 && wr_d[2] == 32'h44, "R7 next executes", wr_d[2], 32'h44);

        // Normal taken jump
        clear_mem();
        imem[0]  = e_ldi(4'h0, 4'd1, 32'd1);
        imem[1]  = e_br(4'h4, 4'h0, 1'b0, 24'd10);
        imem[2]  = e_ldi(4'h0, 4'd2, 32'hBAD);
        imem[3]  = e_ldi(4'h0, 4'd3, 32'hBAD);
        imem[10] = e_ldi(4'h0, 4'd4, 32'h10);
        run(14);
        chk(when(10) == when(1) + 3, "R8 target latency", when(10) - when(1), 3);
        chk(when(2) == -1 && when(3) == -1 && nwr == 2 && wr_r[1] == 4'd4, "R8 slots discarded",
            nwr, 2);

        // Delayed jump
        clear_mem();
        imem[0]  = e_ldi(4'h0, 4'd1, 32'd1);
        imem[1]  = e_br(4'h4, 4'h0, 1'b1, 24'd10);
        imem[2]  = e_ldi(4'h0, 4'd2, 32'h22);
        imem[3]  = e_ldi(4'h0, 4'd3, 32'h33);
        imem[4]  = e_ldi(4'h0, 4'd5, 32'hBAD);
        imem[10] = e_ldi(4'h0, 4'd4, 32'h10);
        run(14);
        chk(when(2) == when(1) + 1 && when(3) == when(1) + 2 && when(10) == when(1) + 3,
            "R9 delay slots then target", when(10) - when(1), 3);
        chk(nwr == 4 && wr_d[1] == 32'h22 && wr_d[2] == 32'h33 && when(4) == -1,
            "R9 slot writes", nwr, 4);

        // Normal call and return
        clear_mem();
        imem[0]  = e_ldi(4'h0, 4'd1, 32'd1);
        imem[1]  = e_br(4'h5, 4'h0, 1'b0, 24'd20);
        imem[2]  = e_ldi(4'h0, 4'd2, 32'h22);
        imem[20] = e_ldi(4'h0, 4'd3, 32'h33);
        imem[21] = e_br(4'h6, 4'h0, 1'b0, 24'd0);
        imem[22] = e_ldi(4'h0, 4'd5, 32'hBAD);
        run(16);
        chk(nex >= 5 && ex_pc[2] == 20 && ex_pc[3] == 21 && ex_pc[4] == 2, "R10 call/return order",
            ex_pc[4], 2);
        chk(when(2) == when(21) + 3 && nwr == 3 && wr_r[2] == 4'd2, "R10 return flush",
            when(2) - when(21), 3);

        // Delayed call and delayed return
        clear_mem();
        imem[0]  = e_ldi(4'h0, 4'd1, 32'd1);
        imem[1]  = e_br(4'h5, 4'h0, 1'b1, 24'd20);
        imem[2]  = e_ldi(4'h0, 4'd2, 32'h22);
        imem[3]  = e_ldi(4'h0, 4'd3, 32'h33);
        imem[4]  = e_ldi(4'h0, 4'd4, 32'h44);
        imem[20] = e_ldi(4'h0, 4'd5, 32'h55);
        imem[21] = e_br(4'h6, 4'h0, 1'b1, 24'd0);
        imem[22] = e_ldi(4'h0, 4'd6, 32'h66);
        imem[23] = e_ldi(4'h0, 4'd7, 32'h77);
        run(18);
        chk(nex >= 9 && ex_pc[4] == 20 && ex_pc[8] == 4, "R10 delayed call returns past slots",
            ex_pc[8], 4);
        chk(nwr == 7 && wr_r[6] == 4'd4 && wr_d[6] == 32'h44, "R10 delayed return writes",
            nwr, 7);

        // Illegal encodings
        clear_mem();
        imem[0] = e_ldi(4'h1, 4'd1, 32'h99);
        imem[1] = {4'hF, 44'h0};
        imem[2] = e_alu(4'h7, 2'd0, 4'd5, 4'd1, 4'd1);
        imem[3] = e_alu(4'h0, 2'd0, 4'd5, 4'd1, 4'd1) | (48'h1 << 36);
        imem[4] = e_ldi(4'h0, 4'd2, 32'd7);
        run(10);
        chk(nill == 4, "R11 illegal strobe count", nill, 4);
        chk(nwr == 1 && wr_r[0] == 4'd2, "R11 illegal has no effect", nwr, 1);

        // Stack overflow
        clear_mem();
        imem[0] = e_br(4'h5, 4'h0, 1'b0, 24'd2);
        imem[2] = e_br(4'h5, 4'h0, 1'b0, 24'd4);
        imem[4] = e_br(4'h5, 4'h0, 1'b0, 24'd6);
        imem[6] = e_br(4'h5, 4'h0, 1'b0, 24'd8);
        imem[8] = e_br(4'h5, 4'h0, 1'b0, 24'd10);
        run(24);
        chk(when(8) > 0 && err_at[when(8)] == 0 && err_at[when(8) + 1] == 1,
            "R12 overflow on fifth call", err_at[when(8) + 1], 1);
        chk(when(10) == when(8) + 3, "R12 overflowing call still taken", when(10) - when(8), 3);

        // Stack underflow
        clear_mem();
        imem[0] = e_br(4'h6, 4'h0, 1'b0, 24'd0);
        imem[1] = e_ldi(4'h0, 4'd1, 32'd5);
        run(10);
        chk(when(1) == when(0) + 1 && nwr == 1, "R12 empty return not taken",
            when(1) - when(0), 1);
        chk(err_at[when(0)] == 0 && end_err == 1, "R12 underflow sticky", end_err, 1);

        // Reset clears the error
        clear_mem();
        run(4);
        chk(rs_err == 0 && end_err == 0, "R1 reset clears stack error", end_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule